// File: doc/BRIEF.md
# Maintenance-Bus Fail-Silence Guard

Each node on a shared multi-master two-wire maintenance bus carries one of these guards. At a programmable interval the guard asks the local bus controller to transmit a probe message whose source and destination are both the node's own address. It then watches the controller's receive strobe for that same frame. When the probe does not return within a programmable deadline, the bus is taken to be shorted or jammed by a babbling transmitter. The guard then removes the node's transmitter from the bus and counts the failure.

A silenced node makes no further probe requests. It waits for the designated bus master to send a re-enable command, which restarts the interval from zero. When the master has identified this node as the faulty one, it issues a kill command. The node then stays off the bus until reset, and later re-enable commands have no effect. The bus controller and the physical layer lie outside this block. The configuration must keep the deadline shorter than the interval.

Top module: `fsilence_guard`

## Requirements
- R1: Reset does all of the following: it clears `send_req`, `silent`, `dead` and `timeout_count`, it sets `tx_enable` to 1, and it starts the interval count from zero.
- R2: `send_req` first reads 1 exactly `cfg_period` clock edges after the guard becomes idle, and never before that.
- R3: Suppose the probe has not returned by the `cfg_deadline`-th edge after `send_req` rises. On that edge, `tx_enable` falls to 0, `silent` rises to 1 and `timeout_count` increases by one. Before that edge, `tx_enable` stays 1.
- R4: A matching frame strobed on any edge of the deadline window returns the guard to idle with no fault recorded. This includes the final edge of the window, where the match beats the timeout. The next `send_req` comes `cfg_period` edges later.
- R5: A frame counts as a match only when all four of these hold: `rx_valid` is 1, `rx_src` equals `node_addr`, `rx_dst` equals `node_addr`, and `rx_opcode` equals the parameter `PROBE_OP` (default 8'hA5). Any other frame is ignored and does not stop a timeout.
- R6: While silent, `send_req` stays 0. A one-cycle `reenable_cmd` returns the guard to idle with the interval restarted, so the next `send_req` comes `cfg_period` edges after that command.
- R7: `kill_cmd` in any state gives `dead`=1 and `tx_enable`=0 on the next edge. Only reset leaves this state, and `reenable_cmd` and the passing of time do not change it.
- R8: `timeout_count` saturates at 255 and holds that value through further timeouts.
- R9: While `send_done` has not arrived, `send_req` is held at 1. The deadline window covers this send phase, so a send that never completes still times out `cfg_deadline` edges after `send_req` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | CNT_W | Idle interval between probes, in cycles (at least 1) |
| cfg_deadline | input | CNT_W | Return deadline, in cycles, counted from `send_req` rise (at least 2) |
| node_addr | input | ADDR_W | This node's bus address |
| send_done | input | 1 | Pulse from the bus controller when the probe transmission completes |
| rx_valid | input | 1 | Strobe marking a received frame header |
| rx_src | input | ADDR_W | Source address of the received frame |
| rx_dst | input | ADDR_W | Destination address of the received frame |
| rx_opcode | input | OP_W | Opcode of the received frame |
| reenable_cmd | input | 1 | Master command that lifts a self-silence |
| kill_cmd | input | 1 | Master command that shuts the node off permanently |
| send_req | output | 1 | Level request to transmit the probe, held until `send_done` |
| tx_enable | output | 1 | Bus transmitter enable |
| silent | output | 1 | Node has silenced itself after a missed probe |
| dead | output | 1 | Node is permanently disabled |
| timeout_count | output | 8 | Saturating count of missed probes |

## Verification
All outputs decode straight from registered state, so each response is due on one known edge. `send_req` appears on the period-th edge after idle begins. A timeout shows on the deadline-th edge after `send_req` rises. A kill or a re-enable takes effect on the edge that samples the command. The bench drives and samples at the falling edge and counts rising edges from the last state change before each sample. The cycle just before every due edge is checked along with the due edge itself, so a response that arrives early or late is caught. The sweep covers every period from 3 to 7 with every legal deadline below it, and places the matching frame on the last edge of the window.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [2:0] {
    FSG_IDLE,
    FSG_SEND,
    FSG_WAIT_RX,
    FSG_SILENT,
    FSG_DEAD
  } fsg_state_e;

  localparam int unsigned FSG_FAULT_W = 8;

endpackage

// File: rtl/fsg_frame_match.sv
module fsg_frame_match #(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned OP_W     = 8,
  parameter logic [OP_W-1:0] PROBE_OP = 8'hA5
) (
  input  logic              rx_valid_i,
  input  logic [ADDR_W-1:0] rx_src_i,
  input  logic [ADDR_W-1:0] rx_dst_i,
  input  logic [OP_W-1:0]   rx_op_i,
  input  logic [ADDR_W-1:0] self_addr_i,
  output logic              hit_o
);

  logic src_ok, dst_ok, op_ok;

  // R5: all three fields must point back at this node's probe
  assign src_ok = (rx_src_i == self_addr_i);
  assign dst_ok = (rx_dst_i == self_addr_i);
  assign op_ok  = (rx_op_i  == PROBE_OP);
  assign hit_o  = rx_valid_i & src_ok & dst_ok & op_ok;

endmodule

// File: rtl/fsg_fault_counter.sv
module fsg_fault_counter #(
  parameter int unsigned W = fsg_pkg::FSG_FAULT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fault_i,
  output logic [W-1:0] count_o
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                       count_o <= '0;
    else if (fault_i && count_o != TOP) count_o <= count_o + 1'b1;
  end

  assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == TOP) |=> (count_o == TOP));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count_o) |-> (count_o == $past(count_o) + 1'b1));

endmodule

// File: rtl/fsg_fsm.sv
module fsg_fsm
  import fsg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] deadline_i,
  input  logic             send_done_i,
  input  logic             hit_i,
  input  logic             reenable_i,
  input  logic             kill_i,
  output fsg_state_e       state_o,
  output logic             fault_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  fsg_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             in_window, period_end, deadline_end;

  assign in_window    = (state_q == FSG_SEND) || (state_q == FSG_WAIT_RX);
  assign period_end   = (cnt_q == period_i - ONE);
  assign deadline_end = (cnt_q == deadline_i - ONE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + ONE;
    fault_o = 1'b0;
    unique case (state_q)
      FSG_IDLE: begin
        if (period_end) begin
          state_d = FSG_SEND;
          cnt_d   = '0;
        end
      end
      FSG_SEND, FSG_WAIT_RX: begin
        if (hit_i) begin
          state_d = FSG_IDLE;
          cnt_d   = '0;
        end else if (deadline_end) begin
          state_d = FSG_SILENT;
          cnt_d   = '0;
          fault_o = 1'b1;
        end else if (state_q == FSG_SEND && send_done_i) begin
          state_d = FSG_WAIT_RX;
        end
      end
      FSG_SILENT: begin
        cnt_d = '0;
        if (reenable_i) state_d = FSG_IDLE;
      end
      FSG_DEAD: cnt_d = '0;
      default: begin
        state_d = FSG_IDLE;
        cnt_d   = '0;
      end
    endcase
    if (kill_i) begin
      state_d = FSG_DEAD;
      cnt_d   = '0;
      fault_o = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FSG_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  assert_dead_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FSG_DEAD) |=> (state_q == FSG_DEAD));

  assert_kill_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> (state_q == FSG_DEAD));

  assert_silent_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FSG_SILENT) && !reenable_i && !kill_i |=> (state_q == FSG_SILENT));

  assert_idle_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_window && !hit_i |=> (state_q != FSG_IDLE));

endmodule

// File: rtl/fsilence_guard.sv
module fsilence_guard
  import fsg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned OP_W     = 8,
  parameter int unsigned CNT_W    = 16,
  parameter logic [OP_W-1:0] PROBE_OP = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_period,
  input  logic [CNT_W-1:0]  cfg_deadline,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic              send_done,
  input  logic              rx_valid,
  input  logic [ADDR_W-1:0] rx_src,
  input  logic [ADDR_W-1:0] rx_dst,
  input  logic [OP_W-1:0]   rx_opcode,
  input  logic              reenable_cmd,
  input  logic              kill_cmd,
  output logic              send_req,
  output logic              tx_enable,
  output logic              silent,
  output logic              dead,
  output logic [FSG_FAULT_W-1:0] timeout_count
);

  logic       hit;
  logic       fault;
  fsg_state_e state;

  fsg_frame_match #(
    .ADDR_W  (ADDR_W),
    .OP_W    (OP_W),
    .PROBE_OP(PROBE_OP)
  ) u_match (
    .rx_valid_i (rx_valid),
    .rx_src_i   (rx_src),
    .rx_dst_i   (rx_dst),
    .rx_op_i    (rx_opcode),
    .self_addr_i(node_addr),
    .hit_o      (hit)
  );

  fsg_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_i   (cfg_period),
    .deadline_i (cfg_deadline),
    .send_done_i(send_done),
    .hit_i      (hit),
    .reenable_i (reenable_cmd),
    .kill_i     (kill_cmd),
    .state_o    (state),
    .fault_o    (fault)
  );

  fsg_fault_counter #(.W(FSG_FAULT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .fault_i(fault),
    .count_o(timeout_count)
  );

  assign send_req  = (state == FSG_SEND);
  assign silent    = (state == FSG_SILENT);
  assign dead      = (state == FSG_DEAD);
  assign tx_enable = !(silent || dead);

  assert_off_bus_on_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!tx_enable && silent));

  assert_no_send_off_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |-> !send_req);

endmodule

// File: tb/fsilence_guard_bench.sv
module fsilence_guard_bench;

  localparam int unsigned ADDR_W = 7;
  localparam int unsigned OP_W   = 8;
  localparam int unsigned CNT_W  = 16;
  localparam logic [OP_W-1:0]   OPC  = 8'hA5;
  localparam logic [ADDR_W-1:0] SELF = 7'h2C;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CNT_W-1:0]  cfg_period = 16'd4;
  logic [CNT_W-1:0]  cfg_deadline = 16'd2;
  logic              send_done = 1'b0;
  logic              rx_valid = 1'b0;
  logic [ADDR_W-1:0] rx_src = '0;
  logic [ADDR_W-1:0] rx_dst = '0;
  logic [OP_W-1:0]   rx_opcode = '0;
  logic              reenable_cmd = 1'b0;
  logic              kill_cmd = 1'b0;
  logic              send_req, tx_enable, silent, dead;
  logic [7:0]        timeout_count;

  int checks = 0;
  int failures = 0;
  bit reported = 1'b0;

  always #2.5 clk = ~clk;

  fsilence_guard #(.ADDR_W(ADDR_W), .OP_W(OP_W), .CNT_W(CNT_W), .PROBE_OP(OPC)) u_fsilence_guard (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_deadline(cfg_deadline),
    .node_addr(SELF), .send_done(send_done), .rx_valid(rx_valid), .rx_src(rx_src),
    .rx_dst(rx_dst), .rx_opcode(rx_opcode), .reenable_cmd(reenable_cmd),
    .kill_cmd(kill_cmd), .send_req(send_req), .tx_enable(tx_enable),
    .silent(silent), .dead(dead), .timeout_count(timeout_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input int p, input int d);
    cfg_period = CNT_W'(p);
    cfg_deadline = CNT_W'(d);
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    chk("R1 send_req", int'(send_req), 0);
    chk("R1 tx_enable", int'(tx_enable), 1);
    chk("R1 silent", int'(silent), 0);
    chk("R1 dead", int'(dead), 0);
    chk("R1 timeout_count", int'(timeout_count), 0);
  endtask

  // waits p edges from idle entry, checking the request arrives exactly then
  task automatic expect_send(input string req, input int p);
    tick(p - 1);
    chk({req, " early send_req"}, int'(send_req), 0);
    tick(1);
    chk({req, " send_req due"}, int'(send_req), 1);
  endtask

  task automatic pulse_done();
    send_done = 1'b1;
    tick(1);
    send_done = 1'b0;
  endtask

  task automatic set_frame(input int kind);
    rx_valid = 1'b1; rx_src = SELF; rx_dst = SELF; rx_opcode = OPC;
    case (kind % 4)
      0: rx_src = SELF ^ 7'h01;
      1: rx_dst = SELF ^ 7'h10;
      2: rx_opcode = OPC ^ 8'h01;
      default: rx_valid = 1'b0;
    endcase
  endtask

  task automatic clear_frame();
    rx_valid = 1'b0; rx_src = '0; rx_dst = '0; rx_opcode = '0;
  endtask

  task automatic run_case(input int p, input int d);
    do_reset(p, d);
    expect_send("R2", p);
    // timeout after a completed send
    pulse_done();
    tick(d - 2);
    chk("R3 tx_enable before deadline", int'(tx_enable), 1);
    chk("R3 silent before deadline", int'(silent), 0);
    tick(1);
    chk("R3 tx_enable at deadline", int'(tx_enable), 0);
    chk("R3 silent at deadline", int'(silent), 1);
    chk("R3 timeout_count", int'(timeout_count), 1);
    for (int i = 0; i < 3; i++) begin
      tick(1);
      chk("R6 no send while silent", int'(send_req), 0);
    end
    reenable_cmd = 1'b1;
    tick(1);
    reenable_cmd = 1'b0;
    chk("R6 tx back on", int'(tx_enable), 1);
    expect_send("R6", p);
    // matching frame on the last edge of the window
    pulse_done();
    tick(d - 2);
    set_frame(99);
    rx_valid = 1'b1; rx_src = SELF; rx_dst = SELF; rx_opcode = OPC;
    tick(1);
    clear_frame();
    chk("R4 tx_enable after late match", int'(tx_enable), 1);
    chk("R4 silent after late match", int'(silent), 0);
    chk("R4 count unchanged", int'(timeout_count), 1);
    expect_send("R4", p);
    // only near-miss frames arrive
    pulse_done();
    for (int e = 2; e <= d; e++) begin
      set_frame(e + p);
      tick(1);
    end
    clear_frame();
    chk("R5 near-miss frames ignored silent", int'(silent), 1);
    chk("R5 near-miss count", int'(timeout_count), 2);
    // permanent shut-off
    kill_cmd = 1'b1;
    tick(1);
    kill_cmd = 1'b0;
    chk("R7 dead", int'(dead), 1);
    chk("R7 tx_enable", int'(tx_enable), 0);
    reenable_cmd = 1'b1;
    tick(1);
    reenable_cmd = 1'b0;
    for (int i = 0; i < p + d; i++) begin
      chk("R7 dead holds", int'(dead), 1);
      chk("R7 no send", int'(send_req), 0);
      tick(1);
    end
    chk("R7 tx stays off", int'(tx_enable), 0);
  endtask

  initial begin
    for (int p = 3; p <= 7; p++)
      for (int d = 2; d < p; d++)
        run_case(p, d);

    // saturation with sends that never complete
    do_reset(3, 2);
    for (int i = 0; i < 260; i++) begin
      tick(3);
      chk("R9 send_req raised", int'(send_req), 1);
      tick(1);
      chk("R9 send_req held", int'(send_req), 1);
      chk("R9 tx on in send", int'(tx_enable), 1);
      tick(1);
      chk("R9 timeout without send_done", int'(silent), 1);
      if (i == 254 || i == 259)
        chk("R8 saturation", int'(timeout_count), (i + 1 > 255) ? 255 : i + 1);
      reenable_cmd = 1'b1;
      tick(1);
      reenable_cmd = 1'b0;
    end
    // kill straight from idle
    kill_cmd = 1'b1;
    tick(1);
    kill_cmd = 1'b0;
    chk("R7 kill from idle", int'(dead), 1);
    chk("R8 count held", int'(timeout_count), 255);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
  end

endmodule